// File: doc/BRIEF.md
# Stored test vector sequencer

This block plays a stored list of wide parallel patterns onto a pin bus, one pattern for each qualified clock. A host fills the vector memory through a load port. Each entry holds a data word and five control flags. The host then writes a configuration word and issues a go command with a 1-based starting vector number. From then on the sequence advances without the host. Its pace comes from one of three clock sources: a divided internal clock, an external drive clock, or a pod sync line. A level on an enable pin can qualify those clocks. Start and stop pins, a handshake pin and loop markers stored in the vectors shape the order of the patterns.

The flags in each vector can end the run, mark the start or end of a loop, hold the run until a handshake edge arrives, or ask for a capture strobe to the response section. That strobe fires on the opposite edge of the vector clock, near the middle of the vector. An active-low tri-state pin turns off the output enable at once. The enable stays off until the host writes a word or the next vector is driven. A two-bit status shows whether a handshake is pending and whether the run reached a stop vector. Every external pin passes through a two-flop synchronizer before edge detection, so a pin event takes effect on the third rising `clk` edge after it changes.

Top module: `vec_sequencer`

## Requirements
- R1: After reset, `dout_oe` is 0, `cap_strobe` is 0 and `status` is 2'b10.
- R2: `ld_we` writes `{ld_ctl, ld_vec}` to address `ld_addr`, which holds vector number `ld_addr+1`. The `ld_ctl` bits are: bit0 stop, bit1 loop head, bit2 loop tail, bit3 handshake wait, bit4 capture. Each qualified clock drives the current vector onto `dout`. After a loop-tail vector, the next vector is the most recently loaded loop-head vector; after any other vector it is the next one in memory. A loop from 2 to 5 entered at 4 yields 4, 5, 2, 3, 4, 5, 2, ...
- R3: `cfg_data[1:0]` selects the clock source: 0 is the internal divider, 1 is `drclk_in`, 2 is the rising edge of `pod_in`. `cfg_data[12]` set makes `drclk_in` active on its falling edge instead of its rising edge. `cfg_data[3:2]` selects an internal rate of 1, 5, 10 or 20 MHz (codes 0 to 3), derived from a `SYS_MHZ` system clock.
- R4: `cfg_data[5:4]` selects the enable mode: 0 means always, 1 means `enable_in` must be high, 2 means `enable_in` must be low. A clock that arrives without the qualifying level leaves the vector position and `dout` unchanged.
- R5: `cfg_data[7:6]` selects how a run starts after `go`: 0 starts at once, 1 waits for a START edge (rising, or falling if `cfg_data[8]` is set), 2 waits for an `arm` pulse. Clocks that arrive before the start condition drive nothing.
- R6: After a vector with the wait flag is driven, `status[1]` reads 0 and clocks are ignored. The handshake edge (rising, or falling if `cfg_data[11]` is set) sets `status[1]` to 1. The next qualified clock then drives the following vector.
- R7: Driving a vector with the stop flag ends the run and sets `status[0]` to 1. Later clocks change nothing, and `status[0]` stays 1 until the next `go`.
- R8: When `cfg_data[9]` is set, a STOP edge (rising, or falling if `cfg_data[10]` is set) ends an armed or running run, and `status[0]` stays 0.
- R9: A low on `tri_n` clears `dout_oe` without waiting for a clock. `dout_oe` stays 0 after `tri_n` returns high, until a host write or a driven vector sets it.
- R10: `host_wr` puts `host_word` on `dout`, sets `dout_oe`, stops any run and discards the loaded file. A later `go` is ignored until a vector is loaded again.
- R11: When a vector with the capture flag is driven, `cap_strobe` pulses high for one cycle on the next opposite-phase event of the clock source: the other edge of `drclk_in`, the falling edge of `pod_in`, or the half-period point of the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Write one vector entry |
| ld_addr | input | AW | Entry address (vector number minus one) |
| ld_vec | input | W | Pattern data of the entry |
| ld_ctl | input | 5 | Control flags of the entry |
| cfg_we | input | 1 | Write the configuration word |
| cfg_data | input | 13 | Configuration word |
| go | input | 1 | Begin a run |
| go_idx | input | AW+1 | 1-based starting vector number |
| arm | input | 1 | Arm pulse for start mode 2 |
| host_wr | input | 1 | Direct host write of the output word |
| host_word | input | W | Word for a direct host write |
| start_in | input | 1 | External START pin |
| stop_in | input | 1 | External STOP pin |
| enable_in | input | 1 | External clock qualifier pin |
| wait_in | input | 1 | Handshake pin |
| drclk_in | input | 1 | External drive clock pin |
| pod_in | input | 1 | Pod sync line |
| tri_n | input | 1 | Active-low asynchronous output disable |
| dout | output | W | Driven pattern |
| dout_oe | output | 1 | Output enable of the pattern |
| cap_strobe | output | 1 | Capture strobe to the response section |
| status | output | 2 | {not waiting, stop vector reached} |

## Verification
The bench uses the defaults: W = 40, DEPTH = 16 and SYS_MHZ = 40. With these values the internal divider ranges from 2 cycles at the 20 MHz setting to 40 cycles at 1 MHz, so a short run covers both the fastest and the slowest rate, including the window before the first slow tick. Sixteen entries leave room for a four-vector loop that is entered part way through, with stop, wait and capture flags on nearby entries. Stepping by `drclk_in` and `pod_in` from the bench gives exact control over edge polarity, enable levels and the start, stop and handshake pins.

// File: rtl/vec_sequencer.sv
module vec_sequencer #(
  parameter int W       = 40,
  parameter int DEPTH   = 16,
  parameter int SYS_MHZ = 40,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_vec,
  input  logic [4:0]    ld_ctl,
  input  logic          cfg_we,
  input  logic [12:0]   cfg_data,
  input  logic          go,
  input  logic [AW:0]   go_idx,
  input  logic          arm,
  input  logic          host_wr,
  input  logic [W-1:0]  host_word,
  input  logic          start_in,
  input  logic          stop_in,
  input  logic          enable_in,
  input  logic          wait_in,
  input  logic          drclk_in,
  input  logic          pod_in,
  input  logic          tri_n,
  output logic [W-1:0]  dout,
  output logic          dout_oe,
  output logic          cap_strobe,
  output logic [1:0]    status
);
  localparam int NW = $clog2(SYS_MHZ);

  logic [12:0]   cfg;
  logic [W+4:0]  mem [DEPTH];
  logic [5:0]    s1, s2, s3;
  logic [NW-1:0] cnt, dmax, dhalf;
  logic [AW-1:0] ptr, loop_head;
  logic          loaded, armed, running, waiting, done, capp;
  logic          tick, half;

  wire [5:0] pins = {enable_in, pod_in, drclk_in, wait_in, stop_in, start_in};
  wire [5:0] rise = s2 & ~s3;
  wire [5:0] fall = ~s2 & s3;

  wire [1:0] src = cfg[1:0];
  wire [1:0] enm = cfg[5:4];
  wire [1:0] stm = cfg[7:6];

  wire start_ev = cfg[8]  ? fall[0] : rise[0];
  wire stop_ev  = cfg[9] & (cfg[10] ? fall[1] : rise[1]);
  wire wait_ev  = cfg[11] ? fall[2] : rise[2];
  wire en_ok    = (enm == 2'd0) | (enm == 2'd1 & s2[5]) | (enm == 2'd2 & ~s2[5]);

  wire [W+4:0]  cur  = mem[ptr];
  wire [4:0]    cctl = cur[W+4:W];
  wire          step = running & ~waiting & tick & en_ok;
  wire [AW-1:0] nxt  = cctl[2] ? loop_head : ptr + 1'b1;

  always_comb begin
    case (cfg[3:2])
      2'd0:    begin dmax = NW'(SYS_MHZ - 1);      dhalf = NW'(SYS_MHZ / 2 - 1);  end
      2'd1:    begin dmax = NW'(SYS_MHZ / 5 - 1);  dhalf = NW'(SYS_MHZ / 10 - 1); end
      2'd2:    begin dmax = NW'(SYS_MHZ / 10 - 1); dhalf = NW'(SYS_MHZ / 20 - 1); end
      default: begin dmax = NW'(SYS_MHZ / 20 - 1); dhalf = NW'(SYS_MHZ / 40 - 1); end
    endcase
  end

  always_comb begin
    case (src)
      2'd0: begin tick = (cnt == dmax); half = (cnt == dhalf); end
      2'd1: begin
        tick = cfg[12] ? fall[3] : rise[3];
        half = cfg[12] ? rise[3] : fall[3];
      end
      default: begin tick = rise[4]; half = fall[4]; end
    endcase
  end

  always_ff @(posedge clk)
    if (ld_we) mem[ld_addr] <= {ld_ctl, ld_vec};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; cnt <= '0;
    end else begin
      s1 <= pins; s2 <= s1; s3 <= s2;
      cnt <= (go || cnt == dmax) ? '0 : cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= '0; dout <= '0; ptr <= '0; loop_head <= '0;
      loaded <= 1'b0; armed <= 1'b0; running <= 1'b0;
      waiting <= 1'b0; done <= 1'b0; capp <= 1'b0; cap_strobe <= 1'b0;
    end else begin
      cap_strobe <= 1'b0;
      if (cfg_we) cfg <= cfg_data;
      if (ld_we) begin
        loaded <= 1'b1;
        if (ld_ctl[1]) loop_head <= ld_addr;
      end
      if (host_wr) begin
        dout <= host_word; loaded <= 1'b0;
        armed <= 1'b0; running <= 1'b0; waiting <= 1'b0;
      end else if (go && loaded) begin
        ptr     <= AW'(go_idx - 1'b1);
        done    <= 1'b0;
        waiting <= 1'b0;
        capp    <= 1'b0;
        armed   <= (stm != 2'd0);
        running <= (stm == 2'd0);
      end else begin
        if (armed && ((stm == 2'd1 && start_ev) || (stm == 2'd2 && arm))) begin
          armed <= 1'b0; running <= 1'b1;
        end
        if (capp && half) begin
          cap_strobe <= 1'b1; capp <= 1'b0;
        end
        if (stop_ev && (armed || running)) begin
          armed <= 1'b0; running <= 1'b0; waiting <= 1'b0;
        end else if (waiting) begin
          if (wait_ev) waiting <= 1'b0;
        end else if (step) begin
          dout <= cur[W-1:0];
          ptr  <= nxt;
          if (cctl[0]) begin running <= 1'b0; done <= 1'b1; end
          if (cctl[3]) waiting <= 1'b1;
          if (cctl[4]) capp <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n or negedge tri_n)
    if (!rst_n)                dout_oe <= 1'b0;
    else if (!tri_n)           dout_oe <= 1'b0;
    else if (host_wr || step)  dout_oe <= 1'b1;

  assign status = {~waiting, done};
endmodule

module vec_sequencer_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tri_n,
  input logic         host_wr,
  input logic         go,
  input logic         step,
  input logic [W-1:0] dout,
  input logic         dout_oe,
  input logic         cap_strobe,
  input logic [1:0]   status
);
  p_tristate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_n |-> !dout_oe);

  p_tristate_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_oe && !host_wr && !step) |=> !dout_oe);

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !go) |=> status[0]);

  p_wait_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[1] && !host_wr) |=> $stable(dout));

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);
endmodule

bind vec_sequencer vec_sequencer_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tri_n(tri_n), .host_wr(host_wr), .go(go),
  .step(step), .dout(dout), .dout_oe(dout_oe), .cap_strobe(cap_strobe),
  .status(status)
);

// File: tb/test_vec_sequencer.sv
module test_vec_sequencer;
  localparam int W = 40;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  // walk rows: {enable level, expected vector number after one drclk pulse}
  localparam logic [4:0] WALK [11] = '{5'h14, 5'h15, 5'h05, 5'h12, 5'h13, 5'h03,
                                       5'h14, 5'h15, 5'h12, 5'h02, 5'h13};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_we = 0, cfg_we = 0, go = 0, arm = 0, host_wr = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0] ld_vec = '0, host_word = '0;
  logic [4:0] ld_ctl = '0;
  logic [12:0] cfg_data = '0;
  logic [AW:0] go_idx = '0;
  logic start_in = 0, stop_in = 0, enable_in = 0, wait_in = 0, drclk_in = 0, pod_in = 0;
  logic tri_n = 1'b1;
  logic [W-1:0] dout;
  logic dout_oe, cap_strobe;
  logic [1:0] status;
  int nchk = 0, nfail = 0, ncap = 0;
  bit finished = 0;

  vec_sequencer #(.W(W), .DEPTH(DEPTH), .SYS_MHZ(40)) i_vec_sequencer (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_vec(ld_vec),
    .ld_ctl(ld_ctl), .cfg_we(cfg_we), .cfg_data(cfg_data), .go(go), .go_idx(go_idx),
    .arm(arm), .host_wr(host_wr), .host_word(host_word), .start_in(start_in),
    .stop_in(stop_in), .enable_in(enable_in), .wait_in(wait_in), .drclk_in(drclk_in),
    .pod_in(pod_in), .tri_n(tri_n), .dout(dout), .dout_oe(dout_oe),
    .cap_strobe(cap_strobe), .status(status));

  always #4 clk = ~clk;
  always @(negedge clk) if (cap_strobe) ncap++;

  function automatic logic [W-1:0] pat(int k);
    return {8'(k) * 8'h11, 32'hC0DE_0000 + 32'(k)};
  endfunction

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic load(int num, logic [4:0] ctl);
    ld_addr = AW'(num - 1); ld_vec = pat(num); ld_ctl = ctl; ld_we = 1;
    ticks(1); ld_we = 0;
  endtask

  task automatic setcfg(logic [12:0] v);
    cfg_data = v; cfg_we = 1; ticks(1); cfg_we = 0;
  endtask

  task automatic start_run(int idx);
    go_idx = (AW+1)'(idx); go = 1; ticks(1); go = 0; ticks(1);
  endtask

  task automatic dr_pulse();
    drclk_in = 1; ticks(4); drclk_in = 0; ticks(4);
  endtask

  task automatic pod_pulse();
    pod_in = 1; ticks(4); pod_in = 0; ticks(4);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    ticks(3); rst_n = 1; ticks(1);
    chk("R1 oe", W'(dout_oe), W'(0));
    chk("R1 status", W'(status), W'(2'b10));
    chk("R1 strobe", W'(cap_strobe), W'(0));

    for (int k = 1; k <= 8; k++)
      load(k, k == 2 ? 5'b00010 : (k == 5 ? 5'b00100 : 5'b00000));
    setcfg(13'h011);
    start_run(4);
    for (int i = 0; i < 11; i++) begin
      enable_in = WALK[i][4]; ticks(3);
      dr_pulse();
      chk(WALK[i][4] ? "R2 loop order" : "R4 disabled hold", dout, pat(int'(WALK[i][3:0])));
    end
    chk("R2 oe", W'(dout_oe), W'(1));
    chk("R2 status", W'(status), W'(2'b10));

    setcfg(13'h1001);
    start_run(1);
    drclk_in = 1; ticks(4);
    chk("R3 falling ignores rise", dout, pat(3));
    drclk_in = 0; ticks(4);
    chk("R3 falling edge", dout, pat(1));

    load(3, 5'b00001);
    setcfg(13'h001);
    start_run(1);
    repeat (3) dr_pulse();
    chk("R7 stop vector", dout, pat(3));
    chk("R7 done", W'(status), W'(2'b11));
    dr_pulse();
    chk("R7 after stop", dout, pat(3));
    chk("R7 done holds", W'(status), W'(2'b11));

    load(2, 5'b01010);
    start_run(1);
    dr_pulse(); dr_pulse();
    chk("R6 wait vector", dout, pat(2));
    chk("R6 waiting", W'(status), W'(2'b00));
    dr_pulse();
    chk("R6 frozen", dout, pat(2));
    wait_in = 1; ticks(4);
    chk("R6 released", W'(status), W'(2'b10));
    dr_pulse();
    chk("R6 resume", dout, pat(3));
    wait_in = 0; ticks(4);

    load(1, 5'b10000);
    start_run(1);
    ncap = 0;
    drclk_in = 1; ticks(4);
    chk("R11 driven", dout, pat(1));
    chk("R11 none yet", W'(ncap), W'(0));
    drclk_in = 0; ticks(4);
    chk("R11 strobe", W'(ncap), W'(1));
    load(1, 5'b00000);
    load(2, 5'b00010);

    setcfg(13'h241);
    start_run(2);
    dr_pulse();
    chk("R5 not started", dout, pat(1));
    start_in = 1; ticks(4);
    dr_pulse();
    chk("R5 start edge", dout, pat(2));
    stop_in = 1; ticks(4);
    dr_pulse();
    chk("R8 stopped", dout, pat(2));
    chk("R8 no done", W'(status), W'(2'b10));
    start_in = 0; stop_in = 0; ticks(4);

    setcfg(13'h081);
    start_run(1);
    dr_pulse();
    chk("R5 not armed", dout, pat(2));
    arm = 1; ticks(1); arm = 0;
    dr_pulse();
    chk("R5 armed", dout, pat(1));

    setcfg(13'h00C);
    start_run(1);
    ticks(20);
    chk("R3 int fast", dout, pat(3));
    chk("R3 int fast done", W'(status), W'(2'b11));
    setcfg(13'h000);
    start_run(1);
    ticks(20);
    chk("R3 int slow pending", W'(status), W'(2'b10));
    ticks(150);
    chk("R3 int slow done", W'(status), W'(2'b11));

    setcfg(13'h002);
    start_run(1);
    pod_pulse();
    chk("R3 pod", dout, pat(1));

    tri_n = 0; #1;
    chk("R9 async off", W'(dout_oe), W'(0));
    ticks(1); tri_n = 1; ticks(4);
    chk("R9 sticky", W'(dout_oe), W'(0));
    host_word = 40'h12_3456_789A; host_wr = 1; ticks(1); host_wr = 0; ticks(1);
    chk("R10 oe", W'(dout_oe), W'(1));
    chk("R10 word", dout, 40'h12_3456_789A);
    start_run(1);
    pod_pulse();
    chk("R10 go ignored", dout, 40'h12_3456_789A);

    tri_n = 0; #1; tri_n = 1; ticks(2);
    chk("R9 off again", W'(dout_oe), W'(0));
    load(1, 5'b00000);
    start_run(1);
    pod_pulse();
    chk("R9 drive restores oe", W'(dout_oe), W'(1));
    chk("R9 drive value", dout, pat(1));

    report();
  end
endmodule